// File: doc/BRIEF.md
# Disk DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both a disk drive and its host controller can use. Its inputs are the drive's identify data, three host capability masks, a requested mode ceiling, and a few configuration flags. It looks at three mode classes in turn, fastest first: ultra-DMA, then multiword DMA, then single-word DMA. The first class that has a usable mode gives the answer. That answer is the class base code plus the index of the highest usable mode bit, clipped to the requested ceiling. The code 0 means that no DMA is possible.

The search starts when `start_i` is pulsed. The block copies every input on that edge, spends one clock cycle on each class it visits, and then pulses `done_o`. At the same time it reports whether the identify data is self-contradictory, meaning two classes both claim a currently selected mode. Mode codes use 0x40 + n for ultra mode n, 0x20 + n for multiword mode n and 0x10 + n for single-word mode n.

Top module: `dma_mode_sel`

## Requirements
- R1: A `start_i` seen while idle is accepted, and all inputs are captured on that edge. Later input changes do not affect the search. A `start_i` seen while `busy_o` is high is ignored and causes no extra `done_o`.
- R2: `done_o` is high for exactly one cycle. It rises 1, 2 or 3 clock edges after the accepting edge, when the search ends in the ultra, multiword or single-word step. `busy_o` is high from the accepting edge until `done_o`, and low while `done_o` is high.
- R3: The ultra class counts only when identify valid bit 2 (`id_valid_i[2]`) is set and the requested mode is at least 0x40. Its mask is `host_udma_mask_i` AND `udma_word_i[7:0]`, and a nonzero mask yields 0x40 plus the index of its highest set bit.
- R4: When the requested mode is above 0x42, the ultra mask loses bits 3 to 6 (mask 0x78) unless `cable80_i` is set. Bit 7 and bits 0 to 2 are kept.
- R5: The multiword class counts only when `id_valid_i[1]` is set and the request is at least 0x20. Its mask is `host_mwdma_mask_i` AND `mwdma_word_i[7:0]`, with base 0x20.
- R6: The single-word class counts when the request is at least 0x10, with base 0x10. When `id_valid_i[1]` is set, its mask is `host_swdma_mask_i` AND `swdma_word_i[7:0]`.
- R7: When `id_valid_i[1]` is clear, the single-word mask comes from `legacy_mode_i`. A value of 1 gives 0x03, a value of 2 gives 0x07, and both are ANDed with `host_swdma_mask_i`. A value of 0 or above 2 gives an empty mask.
- R8: The reported mode is the smaller of the class result and the request. A request below 0x10, or empty masks in every class, gives 0 after the single-word step.
- R9: When `non_disk_i` and `no_pkt_dma_i` are both set, the result is 0 and `done_o` comes after one step.
- R10: `bad_id_o` is set when `id_valid_i[2]` is set and both `udma_word_i[15:8]` and `mwdma_word_i[15:8]` are nonzero. When only `id_valid_i[1]` is set, it is set if both `mwdma_word_i[15:8]` and `swdma_word_i[15:8]` are nonzero. Otherwise it is clear.
- R11: Reset clears `mode_o`, `bad_id_o`, `busy_o` and `done_o`. `mode_o` and `bad_id_o` keep their values between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (taken while idle) |
| id_valid_i | input | 2 | Identify valid bits 2 and 1 |
| udma_word_i | input | 16 | Drive ultra word: low byte supported, high byte selected |
| mwdma_word_i | input | 16 | Drive multiword word: low supported, high selected |
| swdma_word_i | input | 16 | Drive single-word word: low supported, high selected |
| legacy_mode_i | input | 8 | Legacy single-word mode number |
| host_udma_mask_i | input | 8 | Host ultra capability mask |
| host_mwdma_mask_i | input | 8 | Host multiword capability mask |
| host_swdma_mask_i | input | 8 | Host single-word capability mask |
| req_mode_i | input | 8 | Requested mode ceiling |
| cable80_i | input | 1 | 80-wire cable detected |
| non_disk_i | input | 1 | Attached device is not a disk |
| no_pkt_dma_i | input | 1 | Host forbids DMA for non-disk devices |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| mode_o | output | 8 | Selected mode code, 0 = no DMA |
| bad_id_o | output | 1 | Identify data contradictory |

## Verification
The assertions check on every cycle that the start and done handshake follows its rules: done is a single-cycle pulse, busy follows an accepted start, and results stay stable between strobes. They also check that every nonzero result lies between 0x10 and the captured ceiling, and that the blocked non-disk case always returns zero. Other behaviours need chosen identify words and host masks, and only the bench scenarios can show them. These are the order in which classes are searched, the removal of fast ultra modes without a cable, the legacy mode conversion, the three completion latencies, and the detection of contradictory identify data.

// File: rtl/dms_pkg.sv
package dms_pkg;

    localparam int MODE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int MASK_W  = 8;
    localparam int N_CLASS = 3;
    localparam int IDX_W   = $clog2(MASK_W);

    localparam logic [MODE_W-1:0] BASE_ULTRA  = 8'h40;
    localparam logic [MODE_W-1:0] BASE_MULTI  = 8'h20;
    localparam logic [MODE_W-1:0] BASE_SINGLE = 8'h10;
    localparam logic [MODE_W-1:0] ULTRA_MODE2 = 8'h42;
    localparam logic [MASK_W-1:0] CABLE_BITS  = 8'h78;

    typedef enum logic [1:0] {
        CL_ULTRA  = 2'd0,
        CL_MULTI  = 2'd1,
        CL_SINGLE = 2'd2
    } xfer_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ULTRA  = 2'd1,
        ST_MULTI  = 2'd2,
        ST_SINGLE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [1:0]        valid;
        logic [WORD_W-1:0] udma;
        logic [WORD_W-1:0] mwdma;
        logic [WORD_W-1:0] swdma;
        logic [MODE_W-1:0] legacy;
        logic [MASK_W-1:0] h_udma;
        logic [MASK_W-1:0] h_mwdma;
        logic [MASK_W-1:0] h_swdma;
        logic [MODE_W-1:0] req_mode;
        logic              cable80;
        logic              non_disk;
        logic              no_pkt_dma;
    } id_snap_t;

    function automatic logic [IDX_W-1:0] top_bit(input logic [MASK_W-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [MODE_W-1:0] class_base(input int c);
        case (c)
            0:       return BASE_ULTRA;
            1:       return BASE_MULTI;
            default: return BASE_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/dms_class_masks.sv
module dms_class_masks
    import dms_pkg::*;
(
    input  id_snap_t                      snap_i,
    output logic [N_CLASS-1:0][MASK_W-1:0] mask_o,
    output logic [N_CLASS-1:0]            allow_o
);

    logic [MASK_W-1:0] ultra_raw;
    logic [MASK_W-1:0] ultra_m;
    logic [MASK_W-1:0] multi_m;
    logic [MASK_W-1:0] single_m;
    logic [MASK_W-1:0] legacy_m;

    always_comb begin
        ultra_raw = snap_i.valid[1] ? (snap_i.h_udma & snap_i.udma[MASK_W-1:0]) : '0;
        if ((snap_i.req_mode > ULTRA_MODE2) && (|(ultra_raw & CABLE_BITS)) && !snap_i.cable80)
            ultra_m = ultra_raw & ~CABLE_BITS;
        else
            ultra_m = ultra_raw;
    end

    always_comb begin
        multi_m = snap_i.valid[0] ? (snap_i.h_mwdma & snap_i.mwdma[MASK_W-1:0]) : '0;
    end

    always_comb begin
        unique case (snap_i.legacy)
            8'd1:    legacy_m = 8'h03;
            8'd2:    legacy_m = 8'h07;
            default: legacy_m = 8'h00;
        endcase
        if (snap_i.valid[0])
            single_m = snap_i.swdma[MASK_W-1:0] & snap_i.h_swdma;
        else
            single_m = legacy_m & snap_i.h_swdma;
    end

    assign mask_o[CL_ULTRA]  = ultra_m;
    assign mask_o[CL_MULTI]  = multi_m;
    assign mask_o[CL_SINGLE] = single_m;

    for (genvar c = 0; c < N_CLASS; c++) begin : g_allow
        assign allow_o[c] = (snap_i.req_mode >= class_base(c));
    end

endmodule

// File: rtl/dms_id_check.sv
module dms_id_check
    import dms_pkg::*;
(
    input  logic [1:0]        valid_i,
    input  logic [WORD_W-1:0] udma_i,
    input  logic [WORD_W-1:0] mwdma_i,
    input  logic [WORD_W-1:0] swdma_i,
    output logic              bad_o
);

    localparam int HI_LO = WORD_W / 2;

    logic u_sel, m_sel, s_sel;

    always_comb begin
        u_sel = |udma_i[WORD_W-1:HI_LO];
        m_sel = |mwdma_i[WORD_W-1:HI_LO];
        s_sel = |swdma_i[WORD_W-1:HI_LO];
        if (valid_i[1])
            bad_o = u_sel && m_sel;
        else if (valid_i[0])
            bad_o = m_sel && s_sel;
        else
            bad_o = 1'b0;
    end

endmodule

// File: rtl/dms_seq.sv
module dms_seq
    import dms_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          block_i,
    input  logic [MODE_W-1:0]             req_i,
    input  logic [N_CLASS-1:0][MASK_W-1:0] mask_i,
    input  logic [N_CLASS-1:0]            allow_i,
    output logic                          load_o,
    output logic                          fin_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [MODE_W-1:0]             mode_o
);

    seq_state_e             st, st_nxt;
    logic [MODE_W-1:0]      mode_q, mode_nxt;
    logic                   done_q;
    logic [N_CLASS-1:0]     hit;
    logic [N_CLASS-1:0][MODE_W-1:0] pick;

    for (genvar c = 0; c < N_CLASS; c++) begin : g_pick
        logic [MODE_W-1:0] raw;
        assign hit[c]  = allow_i[c] && (|mask_i[c]);
        assign raw     = class_base(c) + MODE_W'(top_bit(mask_i[c]));
        assign pick[c] = (raw < req_i) ? raw : req_i;
    end

    always_comb begin
        st_nxt   = st;
        fin_o    = 1'b0;
        mode_nxt = mode_q;
        unique case (st)
            ST_IDLE: begin
                if (start_i) st_nxt = ST_ULTRA;
            end
            ST_ULTRA: begin
                if (block_i) begin
                    fin_o = 1'b1; mode_nxt = '0; st_nxt = ST_IDLE;
                end else if (hit[CL_ULTRA]) begin
                    fin_o = 1'b1; mode_nxt = pick[CL_ULTRA]; st_nxt = ST_IDLE;
                end else begin
                    st_nxt = ST_MULTI;
                end
            end
            ST_MULTI: begin
                if (hit[CL_MULTI]) begin
                    fin_o = 1'b1; mode_nxt = pick[CL_MULTI]; st_nxt = ST_IDLE;
                end else begin
                    st_nxt = ST_SINGLE;
                end
            end
            ST_SINGLE: begin
                fin_o    = 1'b1;
                mode_nxt = hit[CL_SINGLE] ? pick[CL_SINGLE] : '0;
                st_nxt   = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            mode_q <= '0;
            done_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= fin_o;
            if (fin_o) mode_q <= mode_nxt;
        end
    end

    assign load_o = (st == ST_IDLE) && start_i;
    assign busy_o = (st != ST_IDLE);
    assign done_o = done_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
    import dms_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:1]        id_valid_i,
    input  logic [15:0]       udma_word_i,
    input  logic [15:0]       mwdma_word_i,
    input  logic [15:0]       swdma_word_i,
    input  logic [7:0]        legacy_mode_i,
    input  logic [7:0]        host_udma_mask_i,
    input  logic [7:0]        host_mwdma_mask_i,
    input  logic [7:0]        host_swdma_mask_i,
    input  logic [7:0]        req_mode_i,
    input  logic              cable80_i,
    input  logic              non_disk_i,
    input  logic              no_pkt_dma_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        mode_o,
    output logic              bad_id_o
);

    id_snap_t                       snap_q;
    logic [N_CLASS-1:0][MASK_W-1:0] masks;
    logic [N_CLASS-1:0]             allow;
    logic                           load, fin, bad_now, bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            if (load) begin
                snap_q.valid      <= id_valid_i;
                snap_q.udma       <= udma_word_i;
                snap_q.mwdma      <= mwdma_word_i;
                snap_q.swdma      <= swdma_word_i;
                snap_q.legacy     <= legacy_mode_i;
                snap_q.h_udma     <= host_udma_mask_i;
                snap_q.h_mwdma    <= host_mwdma_mask_i;
                snap_q.h_swdma    <= host_swdma_mask_i;
                snap_q.req_mode   <= req_mode_i;
                snap_q.cable80    <= cable80_i;
                snap_q.non_disk   <= non_disk_i;
                snap_q.no_pkt_dma <= no_pkt_dma_i;
            end
            if (fin) bad_q <= bad_now;
        end
    end

    dms_class_masks u_masks (
        .snap_i  (snap_q),
        .mask_o  (masks),
        .allow_o (allow)
    );

    dms_id_check u_idchk (
        .valid_i (snap_q.valid),
        .udma_i  (snap_q.udma),
        .mwdma_i (snap_q.mwdma),
        .swdma_i (snap_q.swdma),
        .bad_o   (bad_now)
    );

    dms_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .block_i (snap_q.non_disk && snap_q.no_pkt_dma),
        .req_i   (snap_q.req_mode),
        .mask_i  (masks),
        .allow_i (allow),
        .load_o  (load),
        .fin_o   (fin),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .mode_o  (mode_o)
    );

    assign bad_id_o = bad_q;

endmodule

// File: rtl/dma_mode_sel_chk.sv
module dma_mode_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] mode_o,
    input logic       bad_id_o,
    input logic [7:0] req_q,
    input logic       blk_q
);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    mode_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_o != 8'h00) |-> (mode_o <= req_q && mode_o >= 8'h10));

    // R9
    block_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && blk_q) |-> (mode_o == 8'h00));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rst)) |-> ($stable(mode_o) && $stable(bad_id_o)));

endmodule

bind dma_mode_sel dma_mode_sel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .mode_o   (mode_o),
    .bad_id_o (bad_id_o),
    .req_q    (snap_q.req_mode),
    .blk_q    (snap_q.non_disk && snap_q.no_pkt_dma)
);

// File: tb/dma_mode_sel_bench.sv
`timescale 1ns/1ps
module dma_mode_sel_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:1]  idv;
    logic [15:0] uw, mw, sw;
    logic [7:0]  leg, hu, hm, hs, req;
    logic        cab, nd, npd;
    logic        busy, done, bad;
    logic [7:0]  mode;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_mode_sel u_dma_mode_sel (
        .clk(clk), .rst(rst), .start_i(start), .id_valid_i(idv),
        .udma_word_i(uw), .mwdma_word_i(mw), .swdma_word_i(sw),
        .legacy_mode_i(leg), .host_udma_mask_i(hu), .host_mwdma_mask_i(hm),
        .host_swdma_mask_i(hs), .req_mode_i(req), .cable80_i(cab),
        .non_disk_i(nd), .no_pkt_dma_i(npd), .busy_o(busy), .done_o(done),
        .mode_o(mode), .bad_id_o(bad)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        idv = 2'b00; uw = 16'h0; mw = 16'h0; sw = 16'h0; leg = 8'h0;
        hu = 8'hFF; hm = 8'h07; hs = 8'h07; req = 8'h46;
        cab = 1'b1; nd = 1'b0; npd = 1'b0;
    endtask

    // pulse start, wait for done, check latency, mode, bad flag and hold
    task automatic run(input string tag, input int e_mode, input int e_lat, input int e_bad);
        int k;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; k = 1;
        chk({tag, " busy"}, int'(busy), 1);
        while (!done && k < 20) begin
            @(negedge clk); k++;
        end
        chk({tag, " latency"}, k - 1, e_lat);
        chk({tag, " mode"}, int'(mode), e_mode);
        chk({tag, " bad"}, int'(bad), e_bad);
        @(negedge clk);
        chk({tag, " hold R11"}, int'({done, mode}), e_mode);
    endtask

    task automatic t_reset();
        chk("R11 reset", int'({busy, done, bad, mode}), 0);
    endtask

    task automatic t_ultra();
        defaults(); idv = 2'b11; uw = 16'h003F; hu = 8'h7F; req = 8'h46;
        run("R3 ultra5", 8'h45, 1, 0);
        cab = 1'b0;
        run("R4 nocable", 8'h42, 1, 0);
        uw = 16'h00FF; hu = 8'hFF; req = 8'h47;
        run("R4 bit7 kept", 8'h47, 1, 0);
        uw = 16'h003F; hu = 8'h7F; req = 8'h42;
        run("R8 ceiling 42", 8'h42, 1, 0);
    endtask

    task automatic t_multi();
        defaults(); idv = 2'b01; mw = 16'h0007; uw = 16'h007F;
        run("R5 mw2", 8'h22, 2, 0);
        idv = 2'b11; uw = 16'h0000;
        run("R5 ultra empty", 8'h22, 2, 0);
        uw = 16'h007F; req = 8'h21;
        run("R3 req below ultra R8", 8'h21, 2, 0);
    endtask

    task automatic t_single();
        defaults(); idv = 2'b01; sw = 16'h0003;
        run("R6 sw1", 8'h11, 3, 0);
        idv = 2'b00; leg = 8'd2; sw = 16'h0000;
        run("R7 legacy2", 8'h12, 3, 0);
        hs = 8'h01;
        run("R7 legacy host", 8'h10, 3, 0);
        hs = 8'h07; leg = 8'd3;
        run("R7 legacy3", 8'h00, 3, 0);
        leg = 8'd0;
        run("R8 nothing", 8'h00, 3, 0);
        idv = 2'b11; uw = 16'h00FF; mw = 16'h0007; req = 8'h0F;
        run("R8 req low", 8'h00, 3, 0);
    endtask

    task automatic t_block();
        defaults(); idv = 2'b11; uw = 16'h003F; nd = 1'b1; npd = 1'b1;
        run("R9 blocked", 8'h00, 1, 0);
        npd = 1'b0;
        run("R9 nondisk allowed", 8'h45, 1, 0);
    endtask

    task automatic t_badid();
        defaults(); idv = 2'b10; uw = 16'h0107; mw = 16'h0407;
        run("R10 ultra+mw", 8'h42, 1, 1);
        idv = 2'b01; mw = 16'h0407; sw = 16'h0407; uw = 16'h0000;
        run("R10 mw+sw", 8'h22, 2, 1);
        idv = 2'b10; uw = 16'h0007;
        run("R10 clean", 8'h42, 1, 0);
    endtask

    task automatic t_busy_ignore();
        int k, extra;
        defaults(); idv = 2'b01; sw = 16'h0003;
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        idv = 2'b11; uw = 16'h003F; mw = 16'h0007; req = 8'h46;
        k = 1;
        @(negedge clk); start = 1'b0; k++;
        while (!done && k < 20) begin
            @(negedge clk); k++;
        end
        chk("R1 busy start latency", k - 1, 3);
        chk("R1 busy start mode", int'(mode), 8'h11);
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R1 no extra done", extra, 0);
        chk("R1 idle after", int'(busy), 0);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        defaults();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ultra();
        t_multi();
        t_single();
        t_block();
        t_badid();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule